// File: doc/BRIEF.md
# Video Line Packet Sequencer

This block turns a line-type code into an ordered run of packet descriptors for a serial display link. A table of sequence entries, one per line type, says which packets a line carries. Each entry has up to three packet slots and a low-power flag. Each slot holds a data type, an enable bit and a 3-bit index into a shared table of 16-bit word counts. When a line starts, the sequencer latches the entry for the requested line type. It then offers one descriptor (data type plus word count) at a time to a downstream packet builder, and moves on only when the builder reports the packet as done. After the last enabled slot it raises an end-of-line strobe. That strobe carries a request to drop the link to low power when the entry asks for it.

The sequence table and the length table come in as flat configuration vectors. The timing generator and the pixel payload path sit outside this block. In a typical setup, the length table holds the horizontal sync width, back porch, active and front porch byte counts, each already reduced by its packet overhead (10 bytes for sync width, 14 for back porch, 8 for front porch). A sync-pulse sync line then runs sync-start, blanking (index 1), sync-end. An active line runs blanking (index 2), 24-bit packed pixels (index 3), blanking (index 4).

Top module: `dsi_line_seq`

## Requirements
- R1: While reset is held and in the first cycle after reset, desc_valid_o, line_done_o, lp_req_o and busy_o are all 0.
- R2: Slot s of a sequence entry (s = 0, 1, 2) uses bits [10s+2:10s] as length index, bits [10s+8:10s+3] as data type and bit 10s+9 as enable. An issued descriptor shows that slot's data type on desc_dtype_o.
- R3: desc_wc_o is the 16-bit length selected by the slot's index. Length i sits in bits [32*(i/2)+15 : 32*(i/2)] of len_table_i for even i, and in bits [32*(i/2)+31 : 32*(i/2)+16] for odd i.
- R4: Enabled slots are issued strictly in the order 0, 1, 2. A disabled slot is skipped, its fields are never shown, and later enabled slots of the same entry are still issued.
- R5: While desc_valid_o is 1 and pkt_done_i is 0, the descriptor stays on the outputs unchanged. The next descriptor, or the end of line, appears in the cycle after pkt_done_i is sampled high.
- R6: An entry with no enabled slot issues no descriptor. line_done_o rises in the cycle after the start is accepted.
- R7: lp_req_o is 1 together with line_done_o exactly when bit 30 of the latched entry is 1. It is 0 at all other times.
- R8: line_start_i is ignored while busy_o is 1. The line in progress keeps its entry and its slot order.
- R9: A line_type_i value of NUM_ENTRIES or more selects an empty entry: no descriptor, and no low-power request.
- R10: line_done_o is a single-cycle strobe. In the following cycle busy_o is 0.
- R11: line_start_i sampled high while idle makes busy_o 1 in the next cycle. Entry e is taken from bits [32e+31:32e] of seq_table_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| seq_table_i | input | NUM_ENTRIES*32 | Sequence entries, entry e in word e |
| len_table_i | input | LEN_ENTRIES*16 | Length table, two 16-bit lengths per 32-bit word |
| line_start_i | input | 1 | Start pulse for a new line |
| line_type_i | input | TYPE_W | Line-type code selecting the sequence entry |
| pkt_done_i | input | 1 | Packet builder has consumed the current descriptor |
| desc_valid_o | output | 1 | A descriptor is on offer |
| desc_dtype_o | output | 6 | Data type of the offered packet |
| desc_wc_o | output | LEN_W | Word count of the offered packet |
| line_done_o | output | 1 | End-of-line strobe |
| lp_req_o | output | 1 | Return-to-low-power request, valid with line_done_o |
| busy_o | output | 1 | A line is in progress |

## Verification
The bound checker watches, on every cycle, the descriptor holding stable while it waits for the builder. It also checks that the low-power request only comes with the end-of-line strobe, that the strobe lasts one cycle and is followed by idle, that no descriptor is offered outside a busy line, and that a start in idle is taken. Only the directed scenarios can show that the right fields are picked: which slot bits form the data type, which half of which length word gives the word count, the order in which slots are skipped and issued, and that an out-of-range code or a start during a busy line leaves the outputs untouched.

// File: rtl/dsi_seq_pkg.sv
package dsi_seq_pkg;
   localparam int ENTRY_W  = 32;
   localparam int SLOT_W   = 10;
   localparam int LIDX_W   = 3;
   localparam int DT_W     = 6;
   localparam int LP_BIT   = 30;
   localparam int MAX_SLOTS = 3;

   typedef struct packed {
      logic              en;
      logic [DT_W-1:0]   dt;
      logic [LIDX_W-1:0] lidx;
   } slot_t;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ISSUE  = 2'd1,
      ST_FINISH = 2'd2
   } seq_state_e;
endpackage

// File: rtl/dsi_seq_slot_unpack.sv
module dsi_seq_slot_unpack
   import dsi_seq_pkg::*;
#(
   parameter int NUM_SLOTS = 3
) (
   input  logic [ENTRY_W-1:0]        entry_i,
   output slot_t [NUM_SLOTS-1:0]     slots_o,
   output logic  [NUM_SLOTS-1:0]     en_o,
   output logic                      lp_o
);
   if (NUM_SLOTS < 1 || NUM_SLOTS > MAX_SLOTS) begin : g_bad_slots
      $error("dsi_seq_slot_unpack: NUM_SLOTS must be 1..3");
   end

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      localparam int BASE = s * SLOT_W;
      assign slots_o[s].lidx = entry_i[BASE +: LIDX_W];
      assign slots_o[s].dt   = entry_i[BASE + LIDX_W +: DT_W];
      assign slots_o[s].en   = entry_i[BASE + LIDX_W + DT_W];
      assign en_o[s]         = slots_o[s].en;
   end

   assign lp_o = entry_i[LP_BIT];

   logic unused_top_bit;
   assign unused_top_bit = entry_i[ENTRY_W-1];
endmodule

// File: rtl/dsi_seq_slot_pick.sv
module dsi_seq_slot_pick #(
   parameter int NUM_SLOTS = 3,
   parameter int IDX_W     = 2
) (
   input  logic [NUM_SLOTS-1:0] en_i,
   input  logic [IDX_W-1:0]     from_i,
   output logic                 found_o,
   output logic [IDX_W-1:0]     idx_o
);
   if ((1 << IDX_W) <= NUM_SLOTS) begin : g_bad_w
      $error("dsi_seq_slot_pick: IDX_W too small to hold NUM_SLOTS");
   end

   // lowest enabled slot at or after from_i
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
         if (en_i[s] && (32'(from_i) <= s)) begin
            found_o = 1'b1;
            idx_o   = IDX_W'(s);
         end
      end
   end
endmodule

// File: rtl/dsi_seq_len_lookup.sv
module dsi_seq_len_lookup
   import dsi_seq_pkg::*;
#(
   parameter int LEN_ENTRIES = 8,
   parameter int LEN_W       = 16
) (
   input  logic [LEN_ENTRIES*LEN_W-1:0] table_i,
   input  logic [LIDX_W-1:0]            idx_i,
   output logic [LEN_W-1:0]             len_o
);
   localparam int WORDS = LEN_ENTRIES / 2;

   if (LEN_ENTRIES < 2 || LEN_ENTRIES > (1 << LIDX_W) || (LEN_ENTRIES % 2) != 0) begin : g_bad_len
      $error("dsi_seq_len_lookup: LEN_ENTRIES must be even and 2..8");
   end

   logic [LEN_W-1:0] even_len [WORDS];
   logic [LEN_W-1:0] odd_len  [WORDS];

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      assign even_len[w] = table_i[(2*w)   * LEN_W +: LEN_W];
      assign odd_len[w]  = table_i[(2*w+1) * LEN_W +: LEN_W];
   end

   always_comb begin
      len_o = '0;
      for (int w = 0; w < WORDS; w++) begin
         if (32'(idx_i) == 2*w)   len_o = even_len[w];
         if (32'(idx_i) == 2*w+1) len_o = odd_len[w];
      end
   end
endmodule

// File: rtl/dsi_line_seq.sv
module dsi_line_seq
   import dsi_seq_pkg::*;
#(
   parameter int NUM_ENTRIES = 12,
   parameter int TYPE_W      = 4,
   parameter int NUM_SLOTS   = 3,
   parameter int LEN_ENTRIES = 8,
   parameter int LEN_W       = 16
) (
   input  logic                           clk_i,
   input  logic                           rst_ni,
   input  logic [NUM_ENTRIES*ENTRY_W-1:0] seq_table_i,
   input  logic [LEN_ENTRIES*LEN_W-1:0]   len_table_i,
   input  logic                           line_start_i,
   input  logic [TYPE_W-1:0]              line_type_i,
   input  logic                           pkt_done_i,
   output logic                           desc_valid_o,
   output logic [DT_W-1:0]                desc_dtype_o,
   output logic [LEN_W-1:0]               desc_wc_o,
   output logic                           line_done_o,
   output logic                           lp_req_o,
   output logic                           busy_o
);
   localparam int SIDX_W = $clog2(NUM_SLOTS + 1);

   if ((1 << TYPE_W) < NUM_ENTRIES) begin : g_bad_type
      $error("dsi_line_seq: TYPE_W cannot address NUM_ENTRIES");
   end
   if (NUM_ENTRIES < 1) begin : g_bad_entries
      $error("dsi_line_seq: NUM_ENTRIES must be at least 1");
   end

   seq_state_e         state_q;
   logic [ENTRY_W-1:0] entry_q;
   logic [SIDX_W-1:0]  slot_q;

   // entry selection; out-of-range codes give an empty entry
   logic [ENTRY_W-1:0] new_entry;
   always_comb begin
      new_entry = '0;
      for (int e = 0; e < NUM_ENTRIES; e++) begin
         if (32'(line_type_i) == e) new_entry = seq_table_i[e*ENTRY_W +: ENTRY_W];
      end
   end

   slot_t [NUM_SLOTS-1:0] new_slots, cur_slots;
   logic  [NUM_SLOTS-1:0] new_en, cur_en;
   logic                  new_lp, cur_lp;

   dsi_seq_slot_unpack #(.NUM_SLOTS(NUM_SLOTS)) u_unpack_new (
      .entry_i (new_entry),
      .slots_o (new_slots),
      .en_o    (new_en),
      .lp_o    (new_lp)
   );

   dsi_seq_slot_unpack #(.NUM_SLOTS(NUM_SLOTS)) u_unpack_cur (
      .entry_i (entry_q),
      .slots_o (cur_slots),
      .en_o    (cur_en),
      .lp_o    (cur_lp)
   );

   // one search unit, fed from the incoming entry when idle
   logic                 idle;
   logic [NUM_SLOTS-1:0] search_en;
   logic [SIDX_W-1:0]    search_from;
   logic                 pick_found;
   logic [SIDX_W-1:0]    pick_idx;

   assign idle        = (state_q == ST_IDLE);
   assign search_en   = idle ? new_en : cur_en;
   assign search_from = idle ? '0 : (slot_q + SIDX_W'(1));

   dsi_seq_slot_pick #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(SIDX_W)) u_pick (
      .en_i    (search_en),
      .from_i  (search_from),
      .found_o (pick_found),
      .idx_o   (pick_idx)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         entry_q <= '0;
         slot_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (line_start_i) begin
                  entry_q <= new_entry;
                  if (pick_found) begin
                     slot_q  <= pick_idx;
                     state_q <= ST_ISSUE;
                  end else begin
                     state_q <= ST_FINISH;
                  end
               end
            end
            ST_ISSUE: begin
               if (pkt_done_i) begin
                  if (pick_found) slot_q <= pick_idx;
                  else            state_q <= ST_FINISH;
               end
            end
            ST_FINISH: state_q <= ST_IDLE;
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

   slot_t cur_slot;
   always_comb begin
      cur_slot = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         if (32'(slot_q) == s) cur_slot = cur_slots[s];
      end
   end

   dsi_seq_len_lookup #(.LEN_ENTRIES(LEN_ENTRIES), .LEN_W(LEN_W)) u_len (
      .table_i (len_table_i),
      .idx_i   (cur_slot.lidx),
      .len_o   (desc_wc_o)
   );

   assign desc_valid_o = (state_q == ST_ISSUE);
   assign desc_dtype_o = cur_slot.dt;
   assign line_done_o  = (state_q == ST_FINISH);
   assign lp_req_o     = line_done_o && cur_lp;
   assign busy_o       = !idle;

   logic unused_new_meta;
   assign unused_new_meta = new_lp ^ (^new_slots) ^ cur_slot.en;
endmodule

// File: rtl/dsi_line_seq_chk.sv
module dsi_line_seq_chk #(
   parameter int LEN_W = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             line_start_i,
   input logic             pkt_done_i,
   input logic             desc_valid_o,
   input logic [5:0]       desc_dtype_o,
   input logic [LEN_W-1:0] desc_wc_o,
   input logic             line_done_o,
   input logic             lp_req_o,
   input logic             busy_o
);
   assert_hold_desc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      desc_valid_o && !pkt_done_i |=> desc_valid_o && $stable(desc_dtype_o) && $stable(desc_wc_o));

   assert_lp_with_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lp_req_o |-> line_done_o);

   assert_done_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      line_done_o |=> !line_done_o && !busy_o);

   assert_valid_in_line_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      desc_valid_o |-> busy_o && !line_done_o);

   assert_start_taken_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o && line_start_i |=> busy_o);
endmodule

bind dsi_line_seq dsi_line_seq_chk #(.LEN_W(LEN_W)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .line_start_i (line_start_i),
   .pkt_done_i   (pkt_done_i),
   .desc_valid_o (desc_valid_o),
   .desc_dtype_o (desc_dtype_o),
   .desc_wc_o    (desc_wc_o),
   .line_done_o  (line_done_o),
   .lp_req_o     (lp_req_o),
   .busy_o       (busy_o)
);

// File: tb/dsi_line_seq_tb.sv
module dsi_line_seq_tb_top;
   localparam int NE = 12;
   localparam int TW = 4;
   localparam int NL = 8;
   localparam int LW = 16;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic              rst_n;
   logic [NE*32-1:0]  seq_table;
   logic [NL*LW-1:0]  len_table;
   logic              line_start;
   logic [TW-1:0]     line_type;
   logic              pkt_done;
   logic              desc_valid;
   logic [5:0]        desc_dtype;
   logic [LW-1:0]     desc_wc;
   logic              line_done;
   logic              lp_req;
   logic              busy;

   logic [31:0]   seq  [NE];
   logic [LW-1:0] lens [NL];

   always_comb begin
      for (int i = 0; i < NE; i++) seq_table[i*32 +: 32] = seq[i];
      // two lengths per word: even index low half, odd index high half (R3)
      for (int w = 0; w < NL/2; w++) len_table[w*32 +: 32] = {lens[2*w+1], lens[2*w]};
   end

   dsi_line_seq #(.NUM_ENTRIES(NE), .TYPE_W(TW), .NUM_SLOTS(3), .LEN_ENTRIES(NL), .LEN_W(LW)) dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .seq_table_i  (seq_table),
      .len_table_i  (len_table),
      .line_start_i (line_start),
      .line_type_i  (line_type),
      .pkt_done_i   (pkt_done),
      .desc_valid_o (desc_valid),
      .desc_dtype_o (desc_dtype),
      .desc_wc_o    (desc_wc),
      .line_done_o  (line_done),
      .lp_req_o     (lp_req),
      .busy_o       (busy)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [9:0] slot(input logic [5:0] dt, input bit en, input logic [2:0] idx);
      return {en, dt, idx};
   endfunction

   function automatic logic [31:0] entry(input logic [9:0] s0, input logic [9:0] s1,
                                         input logic [9:0] s2, input bit lp);
      return {1'b0, lp, s2, s1, s0};
   endfunction

   task automatic start_line(input int code);
      line_type  = TW'(code);
      line_start = 1'b1;
      @(negedge clk);
      line_start = 1'b0;
   endtask

   task automatic expect_pkt(input string tag, input logic [5:0] dt, input int idx);
      chk({tag, " valid"}, 32'(desc_valid), 32'd1);
      chk({tag, " dtype"}, 32'(desc_dtype), 32'(dt));
      chk({tag, " wc"},    32'(desc_wc),    32'(lens[idx]));
      pkt_done = 1'b1;
      @(negedge clk);
      pkt_done = 1'b0;
   endtask

   task automatic expect_end(input string tag, input bit lp);
      chk({tag, " no desc at end"}, 32'(desc_valid), 32'd0);
      chk({tag, " line_done"},      32'(line_done),  32'd1);
      chk({tag, " lp_req"},         32'(lp_req),     32'(lp));
      @(negedge clk);
      chk({tag, " done strobe R10"}, 32'(line_done), 32'd0);
      chk({tag, " idle after R10"},  32'(busy),      32'd0);
      chk({tag, " lp low after R7"}, 32'(lp_req),    32'd0);
   endtask

   task automatic t_reset();
      chk("R1 valid in reset", 32'(desc_valid), 32'd0);
      chk("R1 done in reset",  32'(line_done),  32'd0);
      chk("R1 busy in reset",  32'(busy),       32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid after reset", 32'(desc_valid), 32'd0);
      chk("R1 lp after reset",    32'(lp_req),     32'd0);
      chk("R1 busy after reset",  32'(busy),       32'd0);
   endtask

   task automatic t_sync_line();
      start_line(0);
      chk("R11 busy after start", 32'(busy), 32'd1);
      expect_pkt("R2 R4 sync slot0", 6'h01, 0);
      expect_pkt("R3 R4 sync slot1", 6'h19, 1);
      expect_pkt("R3 R4 sync slot2", 6'h31, 0);
      expect_end("R7 sync line lp", 1'b1);
   endtask

   task automatic t_active_line();
      start_line(1);
      expect_pkt("R2 active slot0", 6'h19, 2);
      expect_pkt("R3 active slot1", 6'h3E, 3);
      expect_pkt("R3 active slot2", 6'h19, 4);
      expect_end("R7 active no lp", 1'b0);
   endtask

   task automatic t_sparse();
      start_line(2);
      expect_pkt("R4 only slot2", 6'h21, 5);
      expect_end("R4 sparse end", 1'b0);
      start_line(3);
      expect_pkt("R4 gap slot0", 6'h09, 6);
      expect_pkt("R4 gap slot2", 6'h29, 7);
      expect_end("R4 gap end lp R7", 1'b1);
   endtask

   task automatic t_empty();
      start_line(4);
      expect_end("R6 zero entry", 1'b0);
      start_line(5);
      expect_end("R6 R7 lp only entry", 1'b1);
      start_line(13);
      expect_end("R9 out of range", 1'b0);
      start_line(11);
      expect_pkt("R11 last entry", 6'h3E, 1);
      expect_end("R11 last entry end", 1'b0);
   endtask

   task automatic t_hold();
      start_line(0);
      for (int k = 0; k < 4; k++) begin
         chk("R5 hold valid", 32'(desc_valid), 32'd1);
         chk("R5 hold dtype", 32'(desc_dtype), 32'h01);
         chk("R5 hold wc",    32'(desc_wc),    32'(lens[0]));
         @(negedge clk);
      end
      expect_pkt("R5 after hold slot0", 6'h01, 0);
      expect_pkt("R5 after hold slot1", 6'h19, 1);
      expect_pkt("R5 after hold slot2", 6'h31, 0);
      expect_end("R5 hold end", 1'b1);
   endtask

   task automatic t_busy_start();
      start_line(1);
      chk("R8 first desc", 32'(desc_dtype), 32'h19);
      line_type  = TW'(4);
      line_start = 1'b1;
      @(negedge clk);
      line_start = 1'b0;
      expect_pkt("R8 kept slot0", 6'h19, 2);
      expect_pkt("R8 kept slot1", 6'h3E, 3);
      expect_pkt("R8 kept slot2", 6'h19, 4);
      expect_end("R8 kept end", 1'b0);
   endtask

   initial begin
      rst_n = 1'b0;
      line_start = 1'b0;
      line_type = '0;
      pkt_done = 1'b0;
      for (int i = 0; i < NL; i++) lens[i] = LW'(16'h1111 * (i + 1) + 16'h0A0 * i);
      for (int i = 0; i < NE; i++) seq[i] = '0;
      seq[0]  = entry(slot(6'h01, 1, 0), slot(6'h19, 1, 1), slot(6'h31, 1, 0), 1);
      seq[1]  = entry(slot(6'h19, 1, 2), slot(6'h3E, 1, 3), slot(6'h19, 1, 4), 0);
      seq[2]  = entry(slot(6'h2A, 0, 7), slot(6'h15, 0, 6), slot(6'h21, 1, 5), 0);
      seq[3]  = entry(slot(6'h09, 1, 6), slot(6'h3F, 0, 7), slot(6'h29, 1, 7), 1);
      seq[5]  = entry(slot(6'h00, 0, 0), slot(6'h00, 0, 0), slot(6'h00, 0, 0), 1);
      seq[11] = entry(slot(6'h3E, 1, 1), slot(6'h00, 0, 0), slot(6'h00, 0, 0), 0);
      repeat (3) @(negedge clk);
      t_reset();
      t_sync_line();
      t_active_line();
      t_sparse();
      t_empty();
      t_hold();
      t_busy_start();
      repeat (2) @(negedge clk);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule